// File: doc/BRIEF.md
# Address-Sequence Command Detector

This block snoops the access stream of an asynchronous-style SRAM port and finds a command that is hidden inside ordinary reads. The host performs a fixed run of six reads, one chip-enable controlled read per step. The first five addresses are a fixed unlock prefix. The address of the sixth read selects the command: one value asks for a store of the array into non-volatile cells, and another asks for a recall. When the run is complete, the detector emits a one-cycle command pulse to a separate controller. That controller does the transfer and is outside this block.

The reads in the run are not consumed: they complete as normal reads on the SRAM side. The detector only watches them. It sees each access as a single-cycle strobe, together with a read/write flag and a 15-bit address. Idle cycles between strobes do not disturb the run. Any access that does not fit the run cancels it. While the downstream controller reports busy, the detector ignores all traffic.

Top module: `seqcmd_detect`

## Requirements
- R1: After synchronous reset, both command outputs are low and the detector is idle, with no prefix step recorded.
- R2: Reads of 0x0E38, 0x31C7, 0x03E0, 0x3C1F and 0x303F in that order, followed by a read of 0x0FC0, raise `cmd_store` in the cycle after the strobe of the sixth read.
- R3: The same five-read prefix followed by a read of 0x0C63 raises `cmd_recall` in the cycle after the strobe of the sixth read.
- R4: A command pulse lasts exactly one cycle, and the two outputs are never high together. After a pulse the detector is idle, so a repeated sixth read on its own issues nothing.
- R5: A read to an unexpected address partway through the prefix cancels the run. No command is issued even if the remaining reads of the run follow.
- R6: A write strobe (`acc_write`=1) cancels the run and never counts as a step, even when it targets the next expected address.
- R7: A read of 0x0E38 that cancels a run is taken as the first step of a new run. Any other cancelling read returns the detector to idle.
- R8: While `busy` is high, strobes are ignored, the detector is held idle and no command is issued.
- R9: Cycles with `acc_valid` low between steps neither advance nor cancel the run.
- R10: A sixth read whose address is neither 0x0FC0 nor 0x0C63 cancels the run without a command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | One-cycle strobe marking a chip-enable controlled access |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_addr | input | 15 | Address of the access |
| busy | input | 1 | Downstream controller busy; holds the detector idle |
| cmd_store | output | 1 | One-cycle store command pulse |
| cmd_recall | output | 1 | One-cycle recall command pulse |

## Verification
The only visible outputs are the two pulses, so a wrong step count stays hidden until the sixth read. At that point it shows up as a missing, extra or wrong command, one cycle after that strobe. For this reason every scenario ends with a full run whose result is known. Each cancel case, whether by a bad read, a write, busy or a bad final address, is followed by the rest of the run, which must issue nothing. Each restart case must issue its command exactly one cycle after the last strobe. Pulse width and exclusivity are checked on the following cycle.

// File: rtl/seqcmd_pkg.sv
package seqcmd_pkg;

    localparam int ADDR_W     = 15;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEP_W-1:0] step_t;

    typedef enum logic [1:0] {
        CMD_NONE   = 2'd0,
        CMD_STORE  = 2'd1,
        CMD_RECALL = 2'd2
    } cmd_e;

    typedef struct packed {
        logic  valid;
        logic  write;
        addr_t addr;
    } access_t;

    localparam step_t LAST_STEP   = step_t'(PREFIX_LEN);
    localparam addr_t STORE_ADDR  = 15'h0FC0;
    localparam addr_t RECALL_ADDR = 15'h0C63;

    // unlock prefix, position 0 first
    function automatic addr_t prefix_addr(input int idx);
        case (idx)
            0:       return 15'h0E38;
            1:       return 15'h31C7;
            2:       return 15'h03E0;
            3:       return 15'h3C1F;
            default: return 15'h303F;
        endcase
    endfunction

endpackage

// File: rtl/seqcmd_decode.sv
module seqcmd_decode
    import seqcmd_pkg::*;
(
    input  access_t acc,
    input  step_t   step,
    output logic    hit_prefix,
    output logic    hit_first,
    output cmd_e    final_cmd
);
    logic [PREFIX_LEN-1:0] match_vec;

    for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_match
        assign match_vec[i] = (acc.addr == prefix_addr(i));
    end

    always_comb begin
        hit_first  = match_vec[0];
        hit_prefix = 1'b0;
        if (step < LAST_STEP)
            hit_prefix = match_vec[step];
    end

    always_comb begin
        if (acc.addr == STORE_ADDR)
            final_cmd = CMD_STORE;
        else if (acc.addr == RECALL_ADDR)
            final_cmd = CMD_RECALL;
        else
            final_cmd = CMD_NONE;
    end
endmodule

// File: rtl/seqcmd_track.sv
module seqcmd_track
    import seqcmd_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    busy,
    input  access_t acc,
    input  logic    hit_prefix,
    input  logic    hit_first,
    input  cmd_e    final_cmd,
    output step_t   step_q,
    output cmd_e    cmd_d
);
    step_t step_d;

    always_comb begin
        step_d = step_q;
        cmd_d  = CMD_NONE;
        if (busy) begin
            step_d = '0;
        end else if (acc.valid) begin
            if (acc.write) begin
                step_d = '0;
            end else if (step_q == LAST_STEP) begin
                cmd_d  = final_cmd;
                step_d = (final_cmd == CMD_NONE && hit_first) ? step_t'(1) : '0;
            end else if (hit_prefix) begin
                step_d = step_q + step_t'(1);
            end else if (hit_first) begin
                step_d = step_t'(1);
            end else begin
                step_d = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) step_q <= '0;
        else     step_q <= step_d;
    end
endmodule

// File: rtl/seqcmd_pulse.sv
module seqcmd_pulse
    import seqcmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e cmd_d,
    output logic store_q,
    output logic recall_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            store_q  <= 1'b0;
            recall_q <= 1'b0;
        end else begin
            store_q  <= (cmd_d == CMD_STORE);
            recall_q <= (cmd_d == CMD_RECALL);
        end
    end
endmodule

// File: rtl/seqcmd_detect.sv
module seqcmd_detect
    import seqcmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              busy,
    output logic              cmd_store,
    output logic              cmd_recall
);
    access_t acc;
    step_t   step_q;
    logic    hit_prefix;
    logic    hit_first;
    cmd_e    final_cmd;
    cmd_e    cmd_d;

    assign acc = '{valid: acc_valid, write: acc_write, addr: acc_addr};

    seqcmd_decode u_decode (
        .acc        (acc),
        .step       (step_q),
        .hit_prefix (hit_prefix),
        .hit_first  (hit_first),
        .final_cmd  (final_cmd)
    );

    seqcmd_track u_track (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .acc        (acc),
        .hit_prefix (hit_prefix),
        .hit_first  (hit_first),
        .final_cmd  (final_cmd),
        .step_q     (step_q),
        .cmd_d      (cmd_d)
    );

    seqcmd_pulse u_pulse (
        .clk      (clk),
        .rst      (rst),
        .cmd_d    (cmd_d),
        .store_q  (cmd_store),
        .recall_q (cmd_recall)
    );
endmodule

// File: rtl/seqcmd_detect_chk.sv
module seqcmd_detect_chk
    import seqcmd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              busy,
    input logic              cmd_store,
    input logic              cmd_recall,
    input step_t             step_q
);
    p_step_range_r1: assert property (@(posedge clk) disable iff (rst)
        step_q <= LAST_STEP);

    p_store_cause_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_store |-> $past(acc_valid && !acc_write && !busy && acc_addr == STORE_ADDR));

    p_recall_cause_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_recall |-> $past(acc_valid && !acc_write && !busy && acc_addr == RECALL_ADDR));

    p_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
        !(cmd_store && cmd_recall));

    p_store_width_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_store |=> !cmd_store);

    p_recall_width_r4: assert property (@(posedge clk) disable iff (rst)
        cmd_recall |=> !cmd_recall);

    p_write_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write) |=> !(cmd_store || cmd_recall));

    p_busy_idle_r8: assert property (@(posedge clk) disable iff (rst)
        busy |=> (step_q == '0 && !cmd_store && !cmd_recall));

    p_gap_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!acc_valid && !busy) |=> $stable(step_q));
endmodule

bind seqcmd_detect seqcmd_detect_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_addr   (acc_addr),
    .busy       (busy),
    .cmd_store  (cmd_store),
    .cmd_recall (cmd_recall),
    .step_q     (step_q)
);

// File: tb/seqcmd_detect_tb_top.sv
`timescale 1ns/1ps
module seqcmd_detect_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [14:0] acc_addr = '0;
    logic        busy = 1'b0;
    logic        cmd_store;
    logic        cmd_recall;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    seqcmd_detect dut_i (
        .clk        (clk),
        .rst        (rst),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_addr   (acc_addr),
        .busy       (busy),
        .cmd_store  (cmd_store),
        .cmd_recall (cmd_recall)
    );

    localparam logic [14:0] A0 = 15'h0E38, A1 = 15'h31C7, A2 = 15'h03E0,
                            A3 = 15'h3C1F, A4 = 15'h303F;
    localparam logic [14:0] ST = 15'h0FC0, RC = 15'h0C63;

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {store,recall} actual=%b expected=%b", req, act, exp);
        end
    endtask

    // one strobe; returns outputs in the cycle after it
    task automatic access(input logic w, input logic [14:0] a, output logic [1:0] res);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_addr = a;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
        res = {cmd_store, cmd_recall};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic prefix(input int upto, input string req);
        logic [1:0] r;
        logic [14:0] seq [5] = '{A0, A1, A2, A3, A4};
        for (int i = 0; i < upto; i++) begin
            access(1'b0, seq[i], r);
            check(req, r, 2'b00);
        end
    endtask

    task automatic t_reset;
        check("R1", {cmd_store, cmd_recall}, 2'b00);
    endtask

    task automatic t_store;
        logic [1:0] r;
        prefix(5, "R2");
        access(1'b0, ST, r);
        check("R2", r, 2'b10);
        @(negedge clk);
        check("R4", {cmd_store, cmd_recall}, 2'b00);
        access(1'b0, ST, r);          // repeat alone: idle after pulse
        check("R4", r, 2'b00);
    endtask

    task automatic t_recall;
        logic [1:0] r;
        prefix(5, "R3");
        access(1'b0, RC, r);
        check("R3", r, 2'b01);
        @(negedge clk);
        check("R4", {cmd_store, cmd_recall}, 2'b00);
    endtask

    task automatic t_gaps;
        logic [1:0] r;
        logic [14:0] seq [5] = '{A0, A1, A2, A3, A4};
        for (int i = 0; i < 5; i++) begin
            access(1'b0, seq[i], r);
            idle(i + 1);
        end
        access(1'b0, ST, r);
        check("R9", r, 2'b10);
    endtask

    task automatic t_bad_read;
        logic [1:0] r;
        prefix(3, "R5");
        access(1'b0, 15'h1234, r);
        access(1'b0, A3, r);
        access(1'b0, A4, r);
        access(1'b0, ST, r);
        check("R5", r, 2'b00);
    endtask

    task automatic t_write;
        logic [1:0] r;
        prefix(2, "R6");
        access(1'b1, A2, r);
        check("R6", r, 2'b00);
        access(1'b0, A2, r);
        access(1'b0, A3, r);
        access(1'b0, A4, r);
        access(1'b0, RC, r);
        check("R6", r, 2'b00);
        access(1'b1, A0, r); access(1'b1, A1, r); access(1'b1, A2, r);
        access(1'b1, A3, r); access(1'b1, A4, r); access(1'b1, ST, r);
        check("R6", r, 2'b00);
    endtask

    task automatic t_restart;
        logic [1:0] r;
        prefix(3, "R7");
        access(1'b0, A0, r);          // cancels, counts as step one
        access(1'b0, A1, r);
        access(1'b0, A2, r);
        access(1'b0, A3, r);
        access(1'b0, A4, r);
        access(1'b0, RC, r);
        check("R7", r, 2'b01);
        prefix(5, "R7");
        access(1'b0, A0, r);          // bad sixth read that restarts
        check("R7", r, 2'b00);
        access(1'b0, A1, r); access(1'b0, A2, r);
        access(1'b0, A3, r); access(1'b0, A4, r);
        access(1'b0, ST, r);
        check("R7", r, 2'b10);
    endtask

    task automatic t_busy;
        logic [1:0] r;
        prefix(4, "R8");
        @(negedge clk); busy = 1'b1;
        @(negedge clk); busy = 1'b0;
        access(1'b0, A4, r);
        access(1'b0, ST, r);
        check("R8", r, 2'b00);
        busy = 1'b1;
        access(1'b0, A0, r); access(1'b0, A1, r); access(1'b0, A2, r);
        access(1'b0, A3, r); access(1'b0, A4, r); access(1'b0, RC, r);
        check("R8", r, 2'b00);
        prefix(5, "R8");             // still busy
        busy = 1'b0;
        access(1'b0, RC, r);
        check("R8", r, 2'b00);
        prefix(5, "R8");
        access(1'b0, RC, r);
        check("R8", r, 2'b01);
    endtask

    task automatic t_bad_last;
        logic [1:0] r;
        prefix(5, "R10");
        access(1'b0, 15'h0000, r);
        check("R10", r, 2'b00);
        access(1'b0, ST, r);
        check("R10", r, 2'b00);
        prefix(5, "R10");
        access(1'b0, ST, r);
        check("R10", r, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_store();
        t_recall();
        t_gaps();
        t_bad_read();
        t_write();
        t_restart();
        t_busy();
        t_bad_last();
        idle(2);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #200000;
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule